// File: doc/BRIEF.md
# SMBus Host Register Front End

This block is the register-side front end of an SMBus host controller. Software reaches it over a byte-wide register port with separate read and write strobes and a small offset. It holds the host status, control, command, target address, two data bytes, a block-data byte and a two-bit auxiliary control field. When software starts a transaction, the block checks the selected protocol and the direction bit. It then either flags a device error or latches one request (protocol, 7-bit target, direction, command, data word) towards a downstream bus engine.

The request is held until the engine answers with a one-cycle response that carries data or an error. The block routes returned data into the data registers, sets the done or device-error status bit, and drives a level interrupt. A start written with interrupts disabled does not issue at once. It only raises the busy bit, and the request goes out on the next status read. A device error that has not been cleared blocks every later transaction until software clears it.

Top module: `smb_host_regs`

## Requirements
- R1: Offsets map as status 0x00, control 0x02, command 0x03, address 0x04, data-low 0x05, data-high 0x06, block byte 0x07, auxiliary 0x0D. The auxiliary field keeps only bits [1:0]. Any other offset reads 0 and ignores writes.
- R2: Writing 1 to status bits [7:1] clears them and writing 0 leaves them. A status write never clears busy (bit 0). Status bits are busy[0], done[1], device error[2], bus error[3], failed[4], alert[5], in-use[6] and byte done[7].
- R3: Control bit 6 (start) is never stored. A control read returns only bits [4:0], where bit 0 is interrupt enable, bit 1 is kill and bits [4:2] are the protocol.
- R4: A control write with start=1 and interrupt enable=1 raises req_valid on the next cycle. The request carries protocol, address bits [7:1], direction (address bit 0, 1 = read), command, and data-high:data-low. It is held stable until rsp_valid.
- R5: A control write with start=1 and interrupt enable=0 sets only busy. The next status read returns busy=1, clears busy and issues the transaction.
- R6: While device error is set, a start issues no request and device error stays set.
- R7: Protocols 5 and 7 set device error and issue nothing. Protocol 6 (I2C block read) with direction write does the same. Protocols 0 to 4 and protocol 6 with direction read are issued.
- R8: A successful response sets done. For a read with protocol 1, 2 or 6, rsp_data[7:0] goes to data-low. For a read with protocol 3, and for protocol 4 in either direction, rsp_data[15:8] goes to data-high and rsp_data[7:0] to data-low.
- R9: An error response sets device error and leaves both data registers unchanged.
- R10: A control write with kill=1 sets failed and clears busy.
- R11: irq is high exactly when interrupt enable is set and any status bit in [7:1] is set.
- R12: After reset, status, control and all other registers read 0, req_valid is 0 and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (status read has side effects) |
| reg_addr | input | AW | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| req_valid | output | 1 | Transaction request pending to engine |
| req_proto | output | 3 | Protocol of the request |
| req_target | output | 7 | 7-bit target address |
| req_read | output | 1 | 1 = read direction |
| req_cmd | output | 8 | Command byte |
| req_data | output | 16 | Write data, high byte first |
| rsp_valid | input | 1 | One-cycle engine completion |
| rsp_err | input | 1 | Completion is an error |
| rsp_data | input | 16 | Returned data |
| irq | output | 1 | Interrupt level |

## Verification
The bench builds the block with AW=6, a wider offset than the default of 4. This makes offsets such as 0x2D reachable, so it can show that a high offset does not alias onto the auxiliary field at 0x0D. Directed sequences run immediate and deferred starts, word writes, word and byte reads, error responses, blocked starts, kill, and the interrupt gating.

// File: rtl/smb_host_regs.sv
module smb_host_regs #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          req_valid,
  output logic [2:0]    req_proto,
  output logic [6:0]    req_target,
  output logic          req_read,
  output logic [7:0]    req_cmd,
  output logic [15:0]   req_data,
  input  logic          rsp_valid,
  input  logic          rsp_err,
  input  logic [15:0]   rsp_data,
  output logic          irq
);
  localparam logic [AW-1:0] O_ST  = AW'(8'h00);
  localparam logic [AW-1:0] O_CTL = AW'(8'h02);
  localparam logic [AW-1:0] O_CMD = AW'(8'h03);
  localparam logic [AW-1:0] O_ADR = AW'(8'h04);
  localparam logic [AW-1:0] O_D0  = AW'(8'h05);
  localparam logic [AW-1:0] O_D1  = AW'(8'h06);
  localparam logic [AW-1:0] O_BLK = AW'(8'h07);
  localparam logic [AW-1:0] O_AUX = AW'(8'h0D);

  logic [7:0] st, ctl, cmd_r, adr_r, d0, d1, blk;
  logic [1:0] aux;
  logic [7:0] st_n;
  logic [2:0] run_proto;
  logic wr_st, wr_ctl, rd_st, start_w, run, bad, go, fail_issue, fire;

  assign wr_st   = reg_wr && reg_addr == O_ST;
  assign wr_ctl  = reg_wr && reg_addr == O_CTL;
  assign rd_st   = reg_rd && reg_addr == O_ST;
  assign start_w = wr_ctl && reg_wdata[6];
  assign run     = (start_w && reg_wdata[0]) || (rd_st && st[0]);
  assign run_proto = wr_ctl ? reg_wdata[4:2] : ctl[4:2];
  assign bad     = run_proto == 3'd5 || run_proto == 3'd7 || (run_proto == 3'd6 && !adr_r[0]);
  assign go         = run && !req_valid && !st[2] && !bad;
  assign fail_issue = run && !req_valid && !st[2] && bad;
  assign fire    = rsp_valid && req_valid;
  assign irq     = ctl[0] && |st[7:1];

  always_comb begin
    st_n = st;
    if (wr_st) st_n[7:1] = st[7:1] & ~reg_wdata[7:1];
    if (start_w && !reg_wdata[0] && !req_valid) st_n[0] = 1'b1;
    if (rd_st && st[0]) st_n[0] = 1'b0;
    if (fail_issue) st_n[2] = 1'b1;
    if (wr_ctl && reg_wdata[1]) begin
      st_n[4] = 1'b1;
      st_n[0] = 1'b0;
    end
    if (fire) begin
      if (rsp_err) st_n[2] = 1'b1;
      else         st_n[1] = 1'b1;
    end
  end

  always_comb begin
    case (reg_addr)
      O_ST:    reg_rdata = st;
      O_CTL:   reg_rdata = {3'b000, ctl[4:0]};
      O_CMD:   reg_rdata = cmd_r;
      O_ADR:   reg_rdata = adr_r;
      O_D0:    reg_rdata = d0;
      O_D1:    reg_rdata = d1;
      O_BLK:   reg_rdata = blk;
      O_AUX:   reg_rdata = {6'b0, aux};
      default: reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= '0; ctl <= '0; cmd_r <= '0; adr_r <= '0;
      d0 <= '0; d1 <= '0; blk <= '0; aux <= '0;
      req_valid <= 1'b0; req_proto <= '0; req_target <= '0;
      req_read <= 1'b0; req_cmd <= '0; req_data <= '0;
    end else begin
      st <= st_n;
      if (reg_wr) begin
        case (reg_addr)
          O_CTL: ctl   <= reg_wdata & 8'hBF;
          O_CMD: cmd_r <= reg_wdata;
          O_ADR: adr_r <= reg_wdata;
          O_D0:  d0    <= reg_wdata;
          O_D1:  d1    <= reg_wdata;
          O_BLK: blk   <= reg_wdata;
          O_AUX: aux   <= reg_wdata[1:0];
          default: ;
        endcase
      end
      if (go) begin
        req_valid  <= 1'b1;
        req_proto  <= run_proto;
        req_target <= adr_r[7:1];
        req_read   <= adr_r[0];
        req_cmd    <= cmd_r;
        req_data   <= {d1, d0};
      end
      if (fire) begin
        req_valid <= 1'b0;
        if (!rsp_err) begin
          if ((req_read && (req_proto == 3'd3)) || req_proto == 3'd4) begin
            d1 <= rsp_data[15:8];
            d0 <= rsp_data[7:0];
          end else if (req_read && (req_proto == 3'd1 || req_proto == 3'd2 || req_proto == 3'd6)) begin
            d0 <= rsp_data[7:0];
          end
        end
      end
    end
  end

  assert_busy_kept_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_st && st[0]) |=> st[0]);
  assert_req_held_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !rsp_valid) |=> (req_valid && $stable(req_proto) && $stable(req_target)
                                   && $stable(req_cmd) && $stable(req_data)));
  assert_deverr_blocks_R6: assert property (@(posedge clk) disable iff (rst)
    (st[2] && !wr_st) |=> !$rose(req_valid));
  assert_err_rsp_R9: assert property (@(posedge clk) disable iff (rst)
    (fire && rsp_err) |=> (st[2] && $stable(d0) && $stable(d1)));
  assert_kill_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_ctl && reg_wdata[1]) |=> (st[4] && !st[0]));
  assert_ctl_mask_R3: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == O_CTL) |-> (reg_rdata[7:5] == 3'b000));
endmodule

// File: tb/tb_smb_host_regs.sv
module tb_smb_host_regs;
  localparam int AW = 6;
  localparam int CLK_P = 10;

  logic clk = 0, rst = 1;
  logic reg_wr = 0, reg_rd = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic req_valid, req_read, irq;
  logic [2:0] req_proto;
  logic [6:0] req_target;
  logic [7:0] req_cmd;
  logic [15:0] req_data;
  logic rsp_valid = 0, rsp_err = 0;
  logic [15:0] rsp_data = '0;
  int n_chk = 0, n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  smb_host_regs #(.AW(AW)) dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_proto(req_proto), .req_target(req_target), .req_read(req_read),
    .req_cmd(req_cmd), .req_data(req_data), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_data(rsp_data), .irq(irq));

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(posedge clk); @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
    reg_addr = a; reg_rd = 1; #1 v = reg_rdata;
    @(posedge clk); @(negedge clk); reg_rd = 0;
  endtask

  task automatic respond(input logic e, input logic [15:0] d);
    rsp_valid = 1; rsp_err = e; rsp_data = d;
    @(posedge clk); @(negedge clk); rsp_valid = 0; rsp_err = 0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(6'h00, v); check("R12 status", v, 8'h00);
    rd(6'h02, v); check("R12 control", v, 8'h00);
    check("R12 req_valid", req_valid, 0);
    check("R12 irq", irq, 0);
  endtask

  task automatic t_map;
    logic [7:0] v;
    wr(6'h0D, 8'hFF); rd(6'h0D, v); check("R1 aux mask", v, 8'h03);
    wr(6'h07, 8'h5A); rd(6'h07, v); check("R1 block byte", v, 8'h5A);
    wr(6'h01, 8'h77); rd(6'h01, v); check("R1 unmapped", v, 8'h00);
    wr(6'h2D, 8'h00); rd(6'h0D, v); check("R1 no alias write", v, 8'h03);
    rd(6'h2D, v); check("R1 no alias read", v, 8'h00);
  endtask

  task automatic t_ctl;
    logic [7:0] v;
    wr(6'h02, 8'hBC); rd(6'h02, v); check("R3 ctl readback", v, 8'h1C);
    check("R3 no start", req_valid, 0);
    wr(6'h02, 8'h00);
  endtask

  task automatic t_w1c_deferred;
    logic [7:0] v;
    wr(6'h04, 8'h00); wr(6'h02, 8'h59);
    check("R7 i2c write no req", req_valid, 0);
    rd(6'h00, v); check("R7 deverr set", v, 8'h04);
    check("R11 irq on", irq, 1);
    wr(6'h02, 8'h40);
    check("R5 no immediate req", req_valid, 0);
    wr(6'h00, 8'hFF);
    rd(6'h00, v); check("R2 busy survives w1c", v, 8'h01);
    check("R5 deferred issue", req_valid, 1);
    rd(6'h00, v); check("R5 busy cleared", v, 8'h00);
    respond(0, 16'h0);
    rd(6'h00, v); check("R8 quick done", v, 8'h02);
    wr(6'h00, 8'h00); rd(6'h00, v); check("R2 zero keeps", v, 8'h02);
    wr(6'h00, 8'h02); rd(6'h00, v); check("R2 clear done", v, 8'h00);
  endtask

  task automatic t_word_write;
    logic [7:0] v;
    wr(6'h04, 8'hA4); wr(6'h03, 8'h3C); wr(6'h05, 8'h11); wr(6'h06, 8'h22);
    wr(6'h02, 8'h4D);
    check("R4 valid", req_valid, 1);
    check("R4 proto", req_proto, 3);
    check("R4 target", req_target, 7'h52);
    check("R4 dir", req_read, 0);
    check("R4 cmd", req_cmd, 8'h3C);
    check("R4 data", req_data, 16'h2211);
    wr(6'h05, 8'h99); @(negedge clk);
    check("R4 held", req_data, 16'h2211);
    respond(0, 16'hFFFF);
    check("R4 drop", req_valid, 0);
    rd(6'h05, v); check("R8 write keeps d0", v, 8'h99);
    check("R11 irq done", irq, 1);
    wr(6'h00, 8'hFE);
  endtask

  task automatic t_reads;
    logic [7:0] v;
    wr(6'h04, 8'hA5); wr(6'h02, 8'h4D);
    respond(0, 16'hBEEF);
    rd(6'h05, v); check("R8 word lo", v, 8'hEF);
    rd(6'h06, v); check("R8 word hi", v, 8'hBE);
    wr(6'h00, 8'hFE);
    wr(6'h02, 8'h49); respond(0, 16'h1234);
    rd(6'h05, v); check("R8 byte lo", v, 8'h34);
    rd(6'h06, v); check("R8 byte keeps hi", v, 8'hBE);
    wr(6'h00, 8'hFE);
  endtask

  task automatic t_err;
    logic [7:0] v;
    wr(6'h05, 8'h55); wr(6'h02, 8'h49); respond(1, 16'h1234);
    rd(6'h00, v); check("R9 deverr", v, 8'h04);
    rd(6'h05, v); check("R9 d0 kept", v, 8'h55);
    rd(6'h06, v); check("R9 d1 kept", v, 8'hBE);
    wr(6'h02, 8'h45);
    check("R6 blocked", req_valid, 0);
    rd(6'h00, v); check("R6 deverr stays", v, 8'h04);
    wr(6'h00, 8'hFE);
    wr(6'h02, 8'h55);
    check("R7 proto5 no req", req_valid, 0);
    rd(6'h00, v); check("R7 proto5 deverr", v, 8'h04);
    wr(6'h00, 8'hFE);
  endtask

  task automatic t_kill_irq;
    logic [7:0] v;
    wr(6'h02, 8'h40);
    rd(6'h02, v); check("R3 start not stored", v, 8'h00);
    wr(6'h02, 8'h02);
    rd(6'h00, v); check("R10 kill", v, 8'h10);
    check("R11 irq gated", irq, 0);
    wr(6'h02, 8'h01); check("R11 irq enabled", irq, 1);
    wr(6'h00, 8'h10); check("R11 irq cleared", irq, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset(); t_map(); t_ctl(); t_w1c_deferred();
        t_word_write(); t_reads(); t_err(); t_kill_irq();
      end
      begin
        repeat (20000) @(negedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule